// File: doc/BRIEF.md
# Oversampling Serial Character Receiver

This block recovers characters from one asynchronous serial line. A sample tick is supplied at sixteen times the bit rate. The line first passes through a synchroniser. An idle receiver watches for a high-to-low transition, then checks the line again halfway into the start bit. If the line has returned high by then, the transition is discarded as noise. Otherwise the receiver samples every later bit once per bit period, at the bit centre, and assembles the character in a shift register.

The frame shape is chosen at run time through configuration inputs:

- five to eight data bits, least significant bit first;
- an optional parity bit, odd or even;
- one or two stop bits.

The finished character goes into a one-entry holding register, which raises a data-ready flag. The character carries its own parity-error and framing-error flags. Software-side logic reads the character and returns a read strobe.

If a new character finishes while the held one is still unread, the new character is discarded and an overrun flag is raised. Each start bit restarts the sample timing, so clock error never accumulates past a single frame.

Top module: `serial_rx`

## Requirements
- R1: After reset, `data_ready`, `rx_valid`, `par_err`, `frm_err` and `ovr_err` are 0 and `rx_data` is 0.
- R2: `cfg_wlen` selects the number of data bits as 5 + `cfg_wlen` (code 0 = 5 bits, code 3 = 8 bits). Data bits arrive least significant first, and `rx_data` bit i holds data bit i. Bits of `rx_data` at or above the word length read 0.
- R3: A low pulse on `rx_line` that has ended before the midpoint of the start bit (8 ticks after the falling edge) is rejected. No character is produced and the next real frame is received correctly.
- R4: When `cfg_par_en` = 1, one parity bit follows the data. With `cfg_par_odd` = 1, the data bits plus the parity bit must hold an odd number of ones; with `cfg_par_odd` = 0, an even number. A mismatch sets `par_err` with that character. When `cfg_par_en` = 0, no parity bit is expected and `par_err` stays 0.
- R5: `cfg_two_stop` = 0 expects one stop bit and `cfg_two_stop` = 1 expects two. If any stop bit is sampled low, `frm_err` is set with that character. The character is still delivered.
- R6: Each accepted character produces a single-cycle `rx_valid` pulse in the cycle where `data_ready` becomes 1. `data_ready`, `rx_data`, `par_err` and `frm_err` then hold until `rd_ack` is pulsed, and `rd_ack` clears `data_ready`.
- R7: A character that completes while `data_ready` = 1 (and `rd_ack` is not asserted in that cycle) is dropped. It sets `ovr_err` and leaves the held character unchanged. `rd_ack` clears `ovr_err`.
- R8: A start bit that begins immediately at the end of the last stop bit, with no idle gap, is detected as a new frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Sample enable, one clock wide, 16 per bit time |
| rx_line | input | 1 | Asynchronous serial input, idle high |
| cfg_wlen | input | 2 | Word length code: data bits = 5 + code |
| cfg_par_en | input | 1 | Parity bit present when 1 |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| cfg_two_stop | input | 1 | 1 = two stop bits, 0 = one |
| rd_ack | input | 1 | Read strobe; releases the held character |
| rx_data | output | 8 | Held character, zero-extended |
| rx_valid | output | 1 | One-cycle strobe when a character is loaded |
| data_ready | output | 1 | Holding register contains an unread character |
| par_err | output | 1 | Parity mismatch on the held character |
| frm_err | output | 1 | Stop bit sampled low on the held character |
| ovr_err | output | 1 | A character was dropped because the holding register was full |

## Verification
The assertions assume that the configuration inputs change only while the receiver is idle and no character is held. The zero-extension check and the hold checks read `cfg_wlen` when they look at the held data.

The stimulus keeps to this. Each frame is acknowledged before the configuration changes, and every frame in the sweep is sent at exactly sixteen ticks per bit. Deliberate faults are limited to a wrong parity bit, a low stop bit, a short start glitch and back-to-back frames with no read in between.

// File: rtl/srx_pkg.sv
package srx_pkg;

    typedef enum logic [2:0] {
        RX_IDLE,
        RX_START,
        RX_DATA,
        RX_PAR,
        RX_STOP
    } srx_state_e;

    localparam int unsigned MIN_BITS = 5;

endpackage

// File: rtl/srx_sync.sv
module srx_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb chain_d = din;
        end else begin : g_many
            always_comb chain_d = {chain_q[STAGES-2:0], din};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '1;
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];

endmodule

// File: rtl/srx_framer.sv
module srx_framer
    import srx_pkg::*;
#(
    parameter int unsigned OVERSAMPLE = 16,
    parameter int unsigned DATA_W     = 8,
    parameter int unsigned WLEN_W     = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              line_s,
    input  logic [WLEN_W-1:0] cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    output logic              done,
    output logic [DATA_W-1:0] char_out,
    output logic              char_perr,
    output logic              char_ferr
);

    localparam int unsigned CNT_W  = $clog2(OVERSAMPLE);
    localparam int unsigned BIDX_W = $clog2(DATA_W);
    localparam int unsigned HALF   = OVERSAMPLE / 2;

    typedef struct packed {
        srx_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BIDX_W-1:0] bidx;
        logic              sidx;
        logic [DATA_W-1:0] shreg;
        logic              par_acc;
        logic              perr;
        logic              ferr;
        logic              last;
        logic              done;
    } frm_t;

    frm_t s_d, s_q;

    logic [BIDX_W-1:0] last_bit;
    logic              bit_mid;
    logic              start_mid;

    assign last_bit  = BIDX_W'(MIN_BITS - 1) + BIDX_W'(cfg_wlen);
    assign bit_mid   = tick && (s_q.cnt == CNT_W'(OVERSAMPLE - 1));
    assign start_mid = tick && (s_q.cnt == CNT_W'(HALF - 1));

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        if (tick) s_d.last = line_s;
        if (tick && s_q.st != RX_IDLE) s_d.cnt = s_q.cnt + CNT_W'(1);

        unique case (s_q.st)
            RX_IDLE: begin
                if (tick && s_q.last && !line_s) begin
                    s_d.st  = RX_START;
                    s_d.cnt = '0;
                end
            end
            RX_START: begin
                if (start_mid) begin
                    if (line_s) begin
                        s_d.st = RX_IDLE;
                    end else begin
                        s_d.st      = RX_DATA;
                        s_d.cnt     = '0;
                        s_d.bidx    = '0;
                        s_d.shreg   = '0;
                        s_d.par_acc = 1'b0;
                        s_d.perr    = 1'b0;
                        s_d.ferr    = 1'b0;
                    end
                end
            end
            RX_DATA: begin
                if (bit_mid) begin
                    s_d.cnt               = '0;
                    s_d.shreg[s_q.bidx]   = line_s;
                    s_d.par_acc           = s_q.par_acc ^ line_s;
                    if (s_q.bidx == last_bit) begin
                        s_d.st   = cfg_par_en ? RX_PAR : RX_STOP;
                        s_d.sidx = 1'b0;
                    end else begin
                        s_d.bidx = s_q.bidx + BIDX_W'(1);
                    end
                end
            end
            RX_PAR: begin
                if (bit_mid) begin
                    s_d.cnt  = '0;
                    s_d.perr = ((s_q.par_acc ^ line_s) != cfg_par_odd);
                    s_d.st   = RX_STOP;
                    s_d.sidx = 1'b0;
                end
            end
            RX_STOP: begin
                if (bit_mid) begin
                    s_d.cnt  = '0;
                    s_d.ferr = s_q.ferr | ~line_s;
                    if (s_q.sidx == cfg_two_stop) begin
                        s_d.done = 1'b1;
                        s_d.st   = RX_IDLE;
                    end else begin
                        s_d.sidx = 1'b1;
                    end
                end
            end
            default: s_d.st = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= RX_IDLE;
            s_q.last <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign done      = s_q.done;
    assign char_out  = s_q.shreg;
    assign char_perr = s_q.perr;
    assign char_ferr = s_q.ferr;

endmodule

// File: rtl/srx_hold.sv
module srx_hold #(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] load_data,
    input  logic              load_perr,
    input  logic              load_ferr,
    input  logic              ack,
    output logic [DATA_W-1:0] data,
    output logic              valid,
    output logic              ready,
    output logic              perr,
    output logic              ferr,
    output logic              ovr
);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              perr;
        logic              ferr;
        logic              ready;
        logic              ovr;
        logic              valid;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d       = h_q;
        h_d.valid = 1'b0;
        if (ack) begin
            h_d.ready = 1'b0;
            h_d.ovr   = 1'b0;
        end
        if (load) begin
            if (h_q.ready && !ack) begin
                h_d.ovr = 1'b1;
            end else begin
                h_d.data  = load_data;
                h_d.perr  = load_perr;
                h_d.ferr  = load_ferr;
                h_d.ready = 1'b1;
                h_d.valid = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign data  = h_q.data;
    assign valid = h_q.valid;
    assign ready = h_q.ready;
    assign perr  = h_q.perr;
    assign ferr  = h_q.ferr;
    assign ovr   = h_q.ovr;

endmodule

// File: rtl/serial_rx.sv
module serial_rx #(
    parameter int unsigned OVERSAMPLE  = 16,
    parameter int unsigned DATA_W      = 8,
    parameter int unsigned WLEN_W      = 2,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              rx_line,
    input  logic [WLEN_W-1:0] cfg_wlen,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_two_stop,
    input  logic              rd_ack,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              data_ready,
    output logic              par_err,
    output logic              frm_err,
    output logic              ovr_err
);

    logic              line_s;
    logic              fr_done;
    logic [DATA_W-1:0] fr_char;
    logic              fr_perr;
    logic              fr_ferr;

    srx_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rx_line),
        .dout (line_s)
    );

    srx_framer #(
        .OVERSAMPLE(OVERSAMPLE),
        .DATA_W    (DATA_W),
        .WLEN_W    (WLEN_W)
    ) i_framer (
        .clk         (clk),
        .rst_n       (rst_n),
        .tick        (tick),
        .line_s      (line_s),
        .cfg_wlen    (cfg_wlen),
        .cfg_par_en  (cfg_par_en),
        .cfg_par_odd (cfg_par_odd),
        .cfg_two_stop(cfg_two_stop),
        .done        (fr_done),
        .char_out    (fr_char),
        .char_perr   (fr_perr),
        .char_ferr   (fr_ferr)
    );

    srx_hold #(.DATA_W(DATA_W)) i_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (fr_done),
        .load_data(fr_char),
        .load_perr(fr_perr),
        .load_ferr(fr_ferr),
        .ack      (rd_ack),
        .data     (rx_data),
        .valid    (rx_valid),
        .ready    (data_ready),
        .perr     (par_err),
        .ferr     (frm_err),
        .ovr      (ovr_err)
    );

endmodule

// File: rtl/srx_checker.sv
module srx_checker #(
    parameter int unsigned DATA_W = 8,
    parameter int unsigned WLEN_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [WLEN_W-1:0] cfg_wlen,
    input logic              cfg_par_en,
    input logic              rd_ack,
    input logic [DATA_W-1:0] rx_data,
    input logic              rx_valid,
    input logic              data_ready,
    input logic              par_err,
    input logic              frm_err,
    input logic              ovr_err
);

    logic [4:0] nbits;
    assign nbits = 5'(5) + 5'(cfg_wlen);

    // R6
    valid_implies_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> data_ready);

    // R6
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R6
    ready_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_ack) |=> data_ready);

    // R7
    held_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (data_ready && !rd_ack) |=> ($stable(rx_data) && $stable(par_err) && $stable(frm_err)));

    // R7
    ack_clears_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |=> !ovr_err);

    // R7
    ovr_needs_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovr_err) |-> $past(data_ready));

    // R2
    upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        data_ready |-> ((rx_data >> nbits) == '0));

    // R4
    par_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !cfg_par_en) |-> !par_err);

endmodule

bind serial_rx srx_checker #(.DATA_W(DATA_W), .WLEN_W(WLEN_W)) i_srx_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_wlen  (cfg_wlen),
    .cfg_par_en(cfg_par_en),
    .rd_ack    (rd_ack),
    .rx_data   (rx_data),
    .rx_valid  (rx_valid),
    .data_ready(data_ready),
    .par_err   (par_err),
    .frm_err   (frm_err),
    .ovr_err   (ovr_err)
);

// File: tb/test_serial_rx.sv
`timescale 1ns/1ps
module test_serial_rx;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       rx_line = 1'b1;
    logic [1:0] cfg_wlen = 2'd3;
    logic       cfg_par_en = 1'b0;
    logic       cfg_par_odd = 1'b0;
    logic       cfg_two_stop = 1'b0;
    logic       rd_ack = 1'b0;
    logic [7:0] rx_data;
    logic       rx_valid;
    logic       data_ready;
    logic       par_err;
    logic       frm_err;
    logic       ovr_err;

    int checks = 0;
    int errors = 0;
    int vcount = 0;
    bit finished = 1'b0;

    localparam int CLK_PER_TICK = 4;
    localparam int CLK_PER_BIT  = 16 * CLK_PER_TICK;

    always #4 clk = ~clk;

    serial_rx i_serial_rx (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rx_line(rx_line),
        .cfg_wlen(cfg_wlen), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
        .cfg_two_stop(cfg_two_stop), .rd_ack(rd_ack), .rx_data(rx_data),
        .rx_valid(rx_valid), .data_ready(data_ready), .par_err(par_err),
        .frm_err(frm_err), .ovr_err(ovr_err)
    );

    initial begin
        int tc = 0;
        forever begin
            @(negedge clk);
            tc = tc + 1;
            tick = (tc % CLK_PER_TICK) == 0;
        end
    end

    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rx_valid) vcount = vcount + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx_line = b;
        repeat (CLK_PER_BIT) @(negedge clk);
    endtask

    // bad_stop: 0 none, 1 first stop low, 2 second stop low
    task automatic send_frame(input logic [7:0] data, input int wbits, input bit pen,
                              input bit podd, input bit two, input bit bad_par,
                              input int bad_stop);
        logic p;
        p = 1'b0;
        send_bit(1'b0);
        for (int i = 0; i < wbits; i++) begin
            send_bit(data[i]);
            p = p ^ data[i];
        end
        if (pen) send_bit(p ^ podd ^ bad_par);
        send_bit(bad_stop == 1 ? 1'b0 : 1'b1);
        if (two) send_bit(bad_stop == 2 ? 1'b0 : 1'b1);
    endtask

    task automatic idle(input int n);
        rx_line = 1'b1;
        repeat (n) @(negedge clk);
    endtask

    task automatic ack_pulse();
        rd_ack = 1'b1;
        @(negedge clk);
        rd_ack = 1'b0;
        @(negedge clk);
    endtask

    // one full frame with its checks and acknowledge
    task automatic run_one(input logic [7:0] data, input int code, input bit pen,
                           input bit podd, input bit two, input bit bad_par,
                           input int bad_stop, input string tag);
        int v0;
        logic [7:0] expd;
        cfg_wlen = 2'(code);
        cfg_par_en = pen;
        cfg_par_odd = podd;
        cfg_two_stop = two;
        v0 = vcount;
        send_frame(data, 5 + code, pen, podd, two, bad_par, bad_stop);
        idle(CLK_PER_BIT);
        expd = data & 8'((1 << (5 + code)) - 1);
        chk(vcount == v0 + 1, {tag, " R6 one valid pulse"}, vcount - v0, 1);
        chk(data_ready == 1'b1, {tag, " R6 ready"}, int'(data_ready), 1);
        chk(rx_data == expd, {tag, " R2 data"}, int'(rx_data), int'(expd));
        chk(par_err == (pen && bad_par), {tag, " R4 parity flag"}, int'(par_err),
            int'(pen && bad_par));
        chk(frm_err == (bad_stop != 0), {tag, " R5 framing flag"}, int'(frm_err),
            int'(bad_stop != 0));
        chk(ovr_err == 1'b0, {tag, " R7 no overrun"}, int'(ovr_err), 0);
        ack_pulse();
        chk(data_ready == 1'b0, {tag, " R6 ack clears ready"}, int'(data_ready), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(data_ready == 1'b0 && rx_valid == 1'b0, "R1 reset flags", int'(data_ready), 0);
        chk(par_err == 1'b0 && frm_err == 1'b0 && ovr_err == 1'b0, "R1 reset errors",
            int'({par_err, frm_err, ovr_err}), 0);
        chk(rx_data == 8'h00, "R1 reset data", int'(rx_data), 0);
        rst_n = 1'b1;
        idle(CLK_PER_BIT);

        // R2 R4 R5 sweep over every frame format
        for (int code = 0; code < 4; code++)
            for (int pen = 0; pen < 2; pen++)
                for (int podd = 0; podd < 2; podd++)
                    for (int two = 0; two < 2; two++) begin
                        run_one(8'hA5, code, 1'(pen), 1'(podd), 1'(two), 1'b0, 0, "sweep");
                        run_one(8'h3C ^ 8'(code * 17), code, 1'(pen), 1'(podd), 1'(two),
                                1'b0, 0, "sweep");
                    end

        // R4 wrong parity, odd and even
        run_one(8'h5B, 3, 1'b1, 1'b1, 1'b0, 1'b1, 0, "R4 odd bad");
        run_one(8'h5B, 2, 1'b1, 1'b0, 1'b1, 1'b1, 0, "R4 even bad");
        run_one(8'hFF, 1, 1'b1, 1'b1, 1'b0, 1'b0, 0, "R4 odd good");

        // R5 framing errors on first and second stop bit
        run_one(8'h81, 3, 1'b0, 1'b0, 1'b0, 1'b0, 1, "R5 stop1 low");
        run_one(8'h0E, 0, 1'b1, 1'b0, 1'b1, 1'b0, 2, "R5 stop2 low");
        run_one(8'h12, 3, 1'b0, 1'b0, 1'b1, 1'b0, 1, "R5 two stop first low");

        // R3 glitch rejection
        begin
            int v0;
            v0 = vcount;
            rx_line = 1'b0;
            repeat (5 * CLK_PER_TICK) @(negedge clk);
            idle(14 * CLK_PER_BIT);
            chk(vcount == v0, "R3 glitch no character", vcount - v0, 0);
            chk(data_ready == 1'b0, "R3 glitch no ready", int'(data_ready), 0);
            run_one(8'h69, 3, 1'b1, 1'b0, 1'b0, 1'b0, 0, "R3 after glitch");
        end

        // R7 R8 back-to-back frames without read
        begin
            int v0;
            cfg_wlen = 2'd3; cfg_par_en = 1'b0; cfg_two_stop = 1'b0;
            v0 = vcount;
            send_frame(8'hC3, 8, 1'b0, 1'b0, 1'b0, 1'b0, 0);
            send_frame(8'h24, 8, 1'b0, 1'b0, 1'b0, 1'b0, 0);
            idle(CLK_PER_BIT);
            chk(ovr_err == 1'b1, "R8 second frame seen, R7 overrun set", int'(ovr_err), 1);
            chk(rx_data == 8'hC3, "R7 held data kept", int'(rx_data), 8'hC3);
            chk(vcount == v0 + 1, "R7 dropped frame no valid", vcount - v0, 1);
            ack_pulse();
            chk(ovr_err == 1'b0 && data_ready == 1'b0, "R7 ack clears overrun",
                int'({ovr_err, data_ready}), 0);
            run_one(8'h7E, 3, 1'b0, 1'b0, 1'b0, 1'b0, 0, "R8 after overrun");
        end

        // R8 back-to-back frames with a read in between
        begin
            cfg_wlen = 2'd1; cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_two_stop = 1'b0;
            send_frame(8'h15, 6, 1'b1, 1'b0, 1'b0, 1'b0, 0);
            fork
                send_frame(8'h2A, 6, 1'b1, 1'b0, 1'b0, 1'b0, 0);
                begin
                    repeat (CLK_PER_BIT) @(negedge clk);
                    chk(rx_data == 8'h15, "R8 first of pair", int'(rx_data), 8'h15);
                    ack_pulse();
                end
            join
            idle(CLK_PER_BIT);
            chk(data_ready == 1'b1 && rx_data == 8'h2A, "R8 second of pair",
                int'(rx_data), 8'h2A);
            chk(ovr_err == 1'b0, "R8 no overrun in pair", int'(ovr_err), 0);
            ack_pulse();
        end

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!finished) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule